// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block sits on the controller side of an asynchronous DRAM. It takes one flat request at a time: read or write, a bank, a row, a column and, for writes, a data nibble. It turns that request into the strobed sequence the device expects on a single shared address bus. The row goes out while the bank's active-low row strobe is low. The column follows while the shared active-low column strobe is low. The write-enable line is low only during the column phase of a write. Read data is captured a fixed number of cycles into the column pulse and returned with a one-cycle completion strobe.

Each of the four banks keeps its own row open after it has been activated, so later requests to the same bank and row skip activation and issue only a column pulse. A request to a different row in an open bank first releases that bank's row strobe for a precharge interval and then reopens the bank with the new row. All timing is counted in clock cycles: row-to-column delay `T_RCD`, column pulse width `T_CAS`, precharge `T_RP`, and read sample point `RD_LAT`, with `RD_LAT < T_CAS`. The default geometry is 4 banks, 14-bit rows, 11-bit columns and 4-bit data, which gives a 1 KB page.

Top module: `dram_page_seq`

## Requirements
- R1: During and right after reset, every bank row strobe, the column strobe and write enable are high, `dq_oe_o` and `done_o` are low, and `req_ready_o` is high.
- R2: A request to a bank with no open row drives that bank's row strobe low with the row on `addr_o` (zero-extended) for exactly `T_RCD` cycles before the column strobe falls.
- R3: The column strobe stays low for exactly `T_CAS` cycles with the column (zero-extended) on `addr_o` and the request bank on `bank_o`, and then stays high for at least one cycle.
- R4: Write enable is low and `dq_oe_o` is high with the write data on `dq_o` throughout the column pulse of a write. During a read and outside the column pulse, write enable is high, `dq_oe_o` is low and `dq_o` is zero.
- R5: For a read, `dq_i` is sampled at the end of column-pulse cycle `RD_LAT`, counting the first low cycle as 0. It appears on `rdata_o` together with a one-cycle `done_o` pulse in the first cycle after the column strobe rises. Writes also give this `done_o` pulse.
- R6: A request whose bank is open on the same row (a page hit) produces no row-strobe activity, and its column pulse starts in the cycle right after it is accepted.
- R7: A request to a bank open on a different row raises that bank's row strobe for exactly `T_RP` cycles and then lowers it with the new row on `addr_o`.
- R8: Accessing one bank never changes the row strobe of any other bank.
- R9: `req_ready_o` is high while idle and low during precharge, activation and the column pulse. In the one cycle after a column pulse it is high only if the presented request is a page hit.
- R10: An opened row stays open (its row strobe low) through idle cycles until a page miss to that bank closes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request taken on this edge if valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| req_wdata_i | input | DQ_W | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DQ_W | Captured read data |
| addr_o | output | ADDR_W | Shared row/column address bus |
| bank_o | output | BANK_W | Bank select |
| ras_no | output | BANKS | Per-bank row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| dq_o | output | DQ_W | Write data to device |
| dq_oe_o | output | 1 | Data output enable |
| dq_i | input | DQ_W | Read data from device |

## Verification
The hardest case to reach is the single cycle after a column pulse, where a new request is taken only if it hits the open page. A miss presented there must be refused and then taken from idle one cycle later. The stimulus list places hits and misses directly behind completed accesses with no idle gap, so this window is exercised both ways. A page miss into an open bank is reached by first opening a row in that bank and then targeting another row there while other banks stay open. The read sample point is checked by changing `dq_i` every cycle, so only a capture in the right cycle returns the expected nibble.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_CAS,
    ST_GAP
  } seq_state_e;
endpackage

// File: rtl/dram_page_table.sv
module dram_page_table #(
  parameter int BANKS = 4,
  parameter int ROW_W = 14,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_set_i,
  input  logic              upd_clr_i,
  input  logic [BANK_W-1:0] upd_bank_i,
  input  logic [ROW_W-1:0]  upd_row_i,
  input  logic [BANK_W-1:0] look_bank_i,
  input  logic [ROW_W-1:0]  look_row_i,
  output logic [BANKS-1:0]  open_o,
  output logic              look_open_o,
  output logic              look_hit_o
);
  logic [ROW_W-1:0] row_q [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (upd_set_i && upd_bank_i == BANK_W'(b)) begin
        open_o[b] <= 1'b1;
        row_q[b]  <= upd_row_i;
      end else if (upd_clr_i && upd_bank_i == BANK_W'(b)) begin
        open_o[b] <= 1'b0;
      end
    end
  end

  assign look_open_o = open_o[look_bank_i];
  assign look_hit_o  = look_open_o && (row_q[look_bank_i] == look_row_i);
endmodule

// File: rtl/dram_phase_timer.sv
module dram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clear_i) cnt_o <= '0;
    else              cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_seq_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 11,
  parameter int DQ_W   = 4,
  parameter int T_RCD  = 3,
  parameter int T_CAS  = 3,
  parameter int T_RP   = 2,
  parameter int RD_LAT = 1,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DQ_W-1:0]   req_wdata_i,
  output logic              done_o,
  output logic [DQ_W-1:0]   rdata_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [BANKS-1:0]  ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  input  logic [DQ_W-1:0]   dq_i
);
  localparam int T_MAX1 = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int T_MAX  = (T_MAX1 > T_RP) ? T_MAX1 : T_RP;
  localparam int CNT_W  = $clog2(T_MAX + 1);

  seq_state_e        state_q, state_d;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              write_q;
  logic [DQ_W-1:0]   wdata_q;
  logic [CNT_W-1:0]  cnt;
  logic [BANKS-1:0]  open_vec;
  logic              look_open, look_hit, accept;
  logic              upd_set, upd_clr;
  logic [BANK_W-1:0] upd_bank;
  logic [ROW_W-1:0]  upd_row;

  dram_page_table #(.BANKS(BANKS), .ROW_W(ROW_W)) u_pages (
    .clk_i, .rst_ni,
    .upd_set_i(upd_set), .upd_clr_i(upd_clr),
    .upd_bank_i(upd_bank), .upd_row_i(upd_row),
    .look_bank_i(req_bank_i), .look_row_i(req_row_i),
    .open_o(open_vec), .look_open_o(look_open), .look_hit_o(look_hit)
  );

  dram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .clear_i(state_d != state_q), .cnt_o(cnt)
  );

  assign req_ready_o = (state_q == ST_IDLE) || (state_q == ST_GAP && look_hit);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = look_hit ? ST_CAS : (look_open ? ST_PRE : ST_ACT);
      ST_PRE:  if (cnt == CNT_W'(T_RP - 1))  state_d = ST_ACT;
      ST_ACT:  if (cnt == CNT_W'(T_RCD - 1)) state_d = ST_CAS;
      ST_CAS:  if (cnt == CNT_W'(T_CAS - 1)) state_d = ST_GAP;
      ST_GAP:  state_d = accept ? ST_CAS : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // page table port: request fields from idle, latched fields after precharge
  always_comb begin
    upd_clr  = (state_q == ST_IDLE) && (state_d == ST_PRE);
    upd_set  = (state_d == ST_ACT) && (state_q != ST_ACT);
    upd_bank = (state_q == ST_IDLE) ? req_bank_i : bank_q;
    upd_row  = (state_q == ST_IDLE) ? req_row_i  : row_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= (state_q == ST_CAS) && (cnt == CNT_W'(T_CAS - 1));
      if (accept) begin
        bank_q  <= req_bank_i;
        row_q   <= req_row_i;
        col_q   <= req_col_i;
        write_q <= req_write_i;
        wdata_q <= req_wdata_i;
      end
      if (state_q == ST_CAS && !write_q && cnt == CNT_W'(RD_LAT)) rdata_o <= dq_i;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ACT:  addr_o = ADDR_W'(row_q);
      ST_CAS:  addr_o = ADDR_W'(col_q);
      default: addr_o = '0;
    endcase
  end

  assign bank_o  = bank_q;
  assign ras_no  = ~open_vec;
  assign cas_no  = (state_q != ST_CAS);
  assign dq_oe_o = (state_q == ST_CAS) && write_q;
  assign we_no   = !dq_oe_o;
  assign dq_o    = dq_oe_o ? wdata_q : '0;
endmodule

// File: rtl/dram_page_seq_chk.sv
module dram_page_seq_chk #(
  parameter int BANKS  = 4,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 14,
  parameter int T_RCD  = 3,
  parameter int T_CAS  = 3,
  parameter int T_RP   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BANK_W-1:0] bank_o,
  input logic [BANKS-1:0]  ras_no,
  input logic              cas_no,
  input logic              we_no,
  input logic              dq_oe_o
);
  int unsigned cas_lo_cnt;
  int unsigned ras_lo_cnt [BANKS];
  int unsigned ras_hi_cnt [BANKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cas_lo_cnt <= 0;
    else if (cas_no) cas_lo_cnt <= 0;
    else             cas_lo_cnt <= cas_lo_cnt + 1;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_ras
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ras_lo_cnt[b] <= 0;
        ras_hi_cnt[b] <= T_RP;
      end else if (ras_no[b]) begin
        ras_lo_cnt[b] <= 0;
        if (ras_hi_cnt[b] < T_RP) ras_hi_cnt[b] <= ras_hi_cnt[b] + 1;
      end else begin
        ras_hi_cnt[b] <= 0;
        if (ras_lo_cnt[b] < T_RCD) ras_lo_cnt[b] <= ras_lo_cnt[b] + 1;
      end
    end

    AST_PRECHARGE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ras_no[b]) |-> ras_hi_cnt[b] >= T_RP); // R7
  end

  AST_WE_IN_CAS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_no |-> (we_no && !dq_oe_o)); // R4
  AST_CAS_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_no && !$past(cas_no)) |-> ($stable(addr_o) && $stable(we_no) && $stable(bank_o))); // R3
  AST_CAS_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_no) |-> cas_lo_cnt == T_CAS); // R3
  AST_DONE_AFTER_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(cas_no)); // R5
  AST_CAS_GIVES_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_no) |-> done_o); // R5
  AST_RCD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> (!ras_no[bank_o] && ras_lo_cnt[bank_o] >= T_RCD)); // R2
  AST_BUSY_IN_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> !req_ready_o); // R9
endmodule

bind dram_page_seq dram_page_seq_chk #(
  .BANKS(BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
  .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o), .done_o(done_o),
  .addr_o(addr_o), .bank_o(bank_o), .ras_no(ras_no), .cas_no(cas_no),
  .we_no(we_no), .dq_oe_o(dq_oe_o)
);

// File: tb/dram_page_seq_tb.sv
`timescale 1ns/1ps
module dram_page_seq_tb;
  localparam int T_RCD = 3, T_CAS = 3, T_RP = 2, RD_LAT = 1;
  localparam int NREQ = 12;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_bank = '0;
  logic [13:0] req_row = '0;
  logic [10:0] req_col = '0;
  logic [3:0] req_wdata = '0, dq_in = '0;
  logic req_ready, done, cas_n, we_n, dq_oe;
  logic [3:0] rdata, dq_out, ras_n;
  logic [13:0] addr;
  logic [1:0] bank;

  always #4 clk = ~clk;

  dram_page_seq #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .RD_LAT(RD_LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_bank_i(req_bank), .req_row_i(req_row),
    .req_col_i(req_col), .req_wdata_i(req_wdata), .done_o(done), .rdata_o(rdata),
    .addr_o(addr), .bank_o(bank), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .dq_i(dq_in));

  // phase: 0 pre, 1 act, 2 cas, 3 gap after cas, 4 idle
  typedef struct {
    int phase; bit hit; bit wr; logic [3:0] ras; logic [13:0] addr;
    logic [1:0] bank; logic [3:0] dq; bit cap;
  } ent_t;

  typedef struct {
    bit wr; logic [1:0] bank; logic [13:0] row; logic [10:0] col; logic [3:0] data; int gap;
  } req_t;

  ent_t exp_q[$];
  req_t reqs[NREQ];
  bit m_open[4];
  logic [13:0] m_row[4];
  logic [1:0] last_bank = '0;
  logic [3:0] exp_rdata = '0;
  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [3:0] ras_vec();
    logic [3:0] v;
    for (int b = 0; b < 4; b++) v[b] = !m_open[b];
    return v;
  endfunction

  function automatic bit m_hit(input logic [1:0] b, input logic [13:0] r);
    return m_open[b] && m_row[b] == r;
  endfunction

  task automatic push_req(input req_t r);
    ent_t e;
    bit hit = m_hit(r.bank, r.row);
    e = '{phase: 0, hit: hit, wr: r.wr, ras: '0, addr: '0, bank: r.bank, dq: '0, cap: 0};
    if (m_open[r.bank] && !hit) begin
      m_open[r.bank] = 0;
      e.ras = ras_vec();
      for (int i = 0; i < T_RP; i++) exp_q.push_back(e);
    end
    if (!hit) begin
      m_open[r.bank] = 1;
      m_row[r.bank] = r.row;
      e.phase = 1; e.ras = ras_vec(); e.addr = r.row;
      for (int i = 0; i < T_RCD; i++) exp_q.push_back(e);
    end
    e.phase = 2; e.ras = ras_vec(); e.addr = 14'(r.col); e.dq = r.wr ? r.data : 4'h0;
    for (int i = 0; i < T_CAS; i++) begin
      e.cap = !r.wr && i == RD_LAT;
      exp_q.push_back(e);
    end
    e.phase = 3; e.addr = '0; e.dq = '0; e.cap = 0;
    exp_q.push_back(e);
    last_bank = r.bank;
  endtask

  task automatic set_req(input int k, input req_t r);
    reqs[k] = r;
  endtask

  initial begin
    set_req(0,  '{0, 2'd0, 14'd5,     11'd3,    4'h0, 0}); // R2 closed bank
    set_req(1,  '{1, 2'd0, 14'd5,     11'd7,    4'hA, 0}); // R6 hit in gap cycle
    set_req(2,  '{0, 2'd0, 14'd5,     11'd2047, 4'h0, 0}); // R3 max column
    set_req(3,  '{0, 2'd1, 14'd16383, 11'd0,    4'h0, 0}); // R9 refused in gap, R8
    set_req(4,  '{0, 2'd0, 14'd5,     11'd1,    4'h0, 3}); // R10 hit after idle
    set_req(5,  '{1, 2'd0, 14'd9,     11'd4,    4'h5, 0}); // R7 miss in open bank
    set_req(6,  '{0, 2'd1, 14'd16383, 11'd5,    4'h0, 0}); // R8 other bank still open
    set_req(7,  '{1, 2'd2, 14'd0,     11'd0,    4'hF, 2});
    set_req(8,  '{1, 2'd3, 14'd1,     11'd1,    4'h3, 0});
    set_req(9,  '{0, 2'd2, 14'd0,     11'd0,    4'h0, 0});
    set_req(10, '{0, 2'd2, 14'd0,     11'd9,    4'h0, 0}); // R6 back-to-back hit
    set_req(11, '{0, 2'd3, 14'd2,     11'd6,    4'h0, 1}); // R7
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int ri, gapc, tail;
    ent_t e;
    bit idle;
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ras", 32'(ras_n), 32'hF);
    chk("R1 cas", 32'(cas_n), 32'h1);
    chk("R1 we", 32'(we_n), 32'h1);
    chk("R1 oe", 32'(dq_oe), 32'h0);
    chk("R1 done", 32'(done), 32'h0);
    chk("R1 ready", 32'(req_ready), 32'h1);
    rst_n = 1;
    ri = 0; gapc = reqs[0].gap; tail = 0;
    while (tail < 6) begin
      @(negedge clk);
      cyc++;
      idle = (exp_q.size() == 0);
      if (idle) e = '{phase: 4, hit: 0, wr: 0, ras: ras_vec(), addr: '0, bank: last_bank, dq: '0, cap: 0};
      else e = exp_q.pop_front();
      if (rst_n && cyc == 1) chk("R1 ready after reset", 32'(req_ready), 32'h1);
      chk(e.phase == 0 ? "R7 ras" : (e.phase == 4 ? "R10 ras" : "R8 ras"), 32'(ras_n), 32'(e.ras));
      chk(e.phase == 1 ? "R2 addr" : "R3 addr", 32'(addr), 32'(e.addr));
      if (e.phase != 4) chk("R3 bank", 32'(bank), 32'(e.bank));
      chk(e.hit ? "R6 cas" : "R3 cas", 32'(cas_n), 32'(e.phase != 2));
      chk("R4 we", 32'(we_n), 32'(!(e.phase == 2 && e.wr)));
      chk("R4 oe", 32'(dq_oe), 32'(e.phase == 2 && e.wr));
      chk("R4 dq", 32'(dq_out), 32'(e.dq));
      chk("R5 done", 32'(done), 32'(e.phase == 3));
      if (e.phase == 3 && !e.wr) chk("R5 rdata", 32'(rdata), 32'(exp_rdata));
      // new read-data value every cycle; capture point must pick this one
      dq_in = 4'(cyc * 7 + 3);
      if (e.cap) exp_rdata = dq_in;
      if (ri < NREQ) begin
        if (gapc > 0) begin
          gapc--;
          req_valid = 0;
        end else begin
          req_valid = 1;
          req_write = reqs[ri].wr; req_bank = reqs[ri].bank; req_row = reqs[ri].row;
          req_col = reqs[ri].col; req_wdata = reqs[ri].data;
        end
      end else begin
        req_valid = 0;
        if (idle) tail++;
      end
      #1;
      chk("R9 ready", 32'(req_ready),
          32'(e.phase == 4 ? 1'b1 : (e.phase == 3 ? m_hit(req_bank, req_row) : 1'b0)));
      if (req_valid && req_ready) begin
        push_req(reqs[ri]);
        ri++;
        if (ri < NREQ) gapc = reqs[ri].gap;
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule